// File: doc/BRIEF.md
# Multi-Cycle Processor Control Sequencer with Trap Capture

This block is the hard-wired controller of a multi-cycle 32-bit processor. The processor has one memory for both instructions and data, and one ALU that is reused from cycle to cycle. The controller steps each instruction through a fetch cycle, a decode and operand-read cycle, and then whichever execute, memory-access and write-back cycles the instruction class needs. In each cycle it drives the datapath selects and load enables: the memory address source, memory read and write, the enables of the instruction, operand, ALU-result and memory-data holding registers, the ALU operand selects and operation code, the register-file write controls, and the next-PC source and write enables.

The controller also detects two kinds of fault. One is an instruction word it cannot decode. The other is signed overflow reported by the ALU during a trapping add or subtract. In either case the sequencer spends one extra state on the fault. In that state it records the address of the faulting instruction, which is the incremented PC minus the step, and a one-bit reason code. It then sends the PC to the handler vector and starts a new fetch. The faulting instruction writes nothing to the register file or to memory.

Every control output comes directly from a flip-flop. The register is loaded with the decode of the next state, so each output changes at the clock edge that enters the state it belongs to.

Top module: `mc_ctrl`

## Requirements
- R1: In the first cycle after reset is released, the outputs show the fetch cycle: mem_rd=1, iord=0, ir_we=1, alu_src_a=0 (PC), alu_src_b=1 (constant step), alu_ctl=4'b0010 (add), pc_src=0 (ALU result), pc_we=1. Every other control output is 0, and epc and cause are 0. In every state, any control field not listed for that state is 0.
- R2: mem_rd and mem_wr are never high together. ir_we is high only with mem_rd=1 and iord=0. Data accesses (mdr_we or mem_wr) drive iord=1.
- R3: The cycle after fetch is always decode: a_we=1, b_we=1, aluout_we=1, alu_src_a=0, alu_src_b=3 (shifted offset), alu_ctl=add.
- R4: Opcode 6'h00 with funct 6'h20 or 6'h21 (add), 6'h22 or 6'h23 (subtract), 6'h24 (and, 4'b0000), 6'h25 (or, 4'b0001) or 6'h2A (set-less-than, 4'b0111) runs in 4 cycles. The execute cycle has alu_src_a=1, alu_src_b=0, aluout_we=1 and alu_ctl from funct, with subtract coded 4'b0110. The write cycle has reg_wr=1, reg_dst=1 (rd) and mem_to_reg=0.
- R5: A load (opcode 6'h23) runs in 5 cycles. The address cycle has alu_src_a=1, alu_src_b=2, alu_ctl=add and aluout_we=1. The read cycle has mem_rd=1, iord=1 and mdr_we=1. The write cycle has reg_wr=1, mem_to_reg=1 and reg_dst=0 (rt).
- R6: A store (opcode 6'h2B) runs in 4 cycles: the same address cycle as a load, then a cycle with mem_wr=1 and iord=1.
- R7: A branch-if-equal (opcode 6'h04) runs in 3 cycles. The last has alu_src_a=1, alu_src_b=0, alu_ctl=subtract, pc_cond=1, pc_src=1 and pc_we=0. A jump (opcode 6'h02) runs in 3 cycles, and the last has pc_we=1 and pc_src=2.
- R8: Add-immediate (6'h08) and and-immediate (6'h0C) run in 4 cycles. The execute cycle has alu_src_a=1, alu_src_b=2, aluout_we=1 and alu_ctl add or and. The write cycle has reg_wr=1 and reg_dst=0.
- R9: Any other opcode, or opcode 6'h00 with a funct not listed in R4, goes from decode into a trap cycle. That cycle has pc_we=1 and pc_src=3 (handler vector) and every other control output 0. The next cycle is a fetch with epc equal to pc_in sampled in the trap cycle minus 4, and cause equal to 0.
- R10: For funct 6'h20 or 6'h22, alu_ovf high in the execute cycle replaces the write cycle with a trap cycle as in R9, and cause becomes 1. For every other instruction, alu_ovf has no effect.
- R11: epc and cause keep their values through every instruction that does not trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ir_opcode | input | 6 | Opcode field of the held instruction |
| ir_funct | input | 6 | Function field of the held instruction |
| alu_ovf | input | 1 | Signed overflow flag from the ALU |
| pc_in | input | ADDR_W | Current PC value |
| mem_rd | output | 1 | Memory read |
| mem_wr | output | 1 | Memory write |
| iord | output | 1 | Memory address select: 0 PC, 1 ALU-result register |
| ir_we | output | 1 | Instruction register load |
| mdr_we | output | 1 | Memory data register load |
| a_we | output | 1 | Operand A register load |
| b_we | output | 1 | Operand B register load |
| aluout_we | output | 1 | ALU-result register load |
| reg_wr | output | 1 | Register file write |
| reg_dst | output | 1 | Write index: 0 rt, 1 rd |
| mem_to_reg | output | 1 | Write data: 0 ALU result, 1 memory data |
| alu_src_a | output | 1 | ALU A: 0 PC, 1 operand A |
| alu_src_b | output | 2 | ALU B: 0 operand B, 1 step, 2 immediate, 3 shifted immediate |
| alu_ctl | output | 4 | ALU operation code |
| pc_we | output | 1 | Unconditional PC write |
| pc_cond | output | 1 | PC write if ALU result is zero |
| pc_src | output | 2 | Next PC: 0 ALU, 1 branch target, 2 jump target, 3 handler |
| epc | output | ADDR_W | Address of the last faulting instruction |
| cause | output | CAUSE_W | Fault reason (bit 0 only) |

## Verification
On every cycle the assertions check the memory-port discipline, the fetch state right after reset, and the trap cycle. For a trap they check that it commits no write, that it is followed by a refetch, that the fault address is loaded as the sampled PC minus the step, and that the reason code stays within one bit. They also check that the fault record stays put in every cycle without a trap. Only the bench's instruction streams can show the cycle-exact control words of each instruction class, the per-funct ALU codes, the choice between trap and write-back for trapping and non-trapping arithmetic, and the detection of undefined words.

// File: rtl/mcc_pkg.sv
package mcc_pkg;

  localparam int OP_W = 6;
  localparam int FN_W = 6;

  localparam logic [OP_W-1:0] OP_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OP_JUMP  = 6'h02;
  localparam logic [OP_W-1:0] OP_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] OP_ADDI  = 6'h08;
  localparam logic [OP_W-1:0] OP_ANDI  = 6'h0C;
  localparam logic [OP_W-1:0] OP_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OP_STORE = 6'h2B;

  localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
  localparam logic [FN_W-1:0] FN_ADDU = 6'h21;
  localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
  localparam logic [FN_W-1:0] FN_SUBU = 6'h23;
  localparam logic [FN_W-1:0] FN_AND  = 6'h24;
  localparam logic [FN_W-1:0] FN_OR   = 6'h25;
  localparam logic [FN_W-1:0] FN_SLT  = 6'h2A;

  localparam logic [3:0] ALU_AND = 4'b0000;
  localparam logic [3:0] ALU_OR  = 4'b0001;
  localparam logic [3:0] ALU_ADD = 4'b0010;
  localparam logic [3:0] ALU_SUB = 4'b0110;
  localparam logic [3:0] ALU_SLT = 4'b0111;

  localparam logic [1:0] SB_REG  = 2'd0;
  localparam logic [1:0] SB_STEP = 2'd1;
  localparam logic [1:0] SB_IMM  = 2'd2;
  localparam logic [1:0] SB_BOFF = 2'd3;

  localparam logic [1:0] PS_ALU = 2'd0;
  localparam logic [1:0] PS_TGT = 2'd1;
  localparam logic [1:0] PS_JMP = 2'd2;
  localparam logic [1:0] PS_VEC = 2'd3;

  typedef enum logic [3:0] {
    S_FETCH, S_DECODE, S_MADDR, S_MREAD, S_MWB, S_MWRITE,
    S_REXEC, S_RWB, S_BRANCH, S_JUMP, S_IEXEC, S_IWB,
    S_XUND, S_XOVF
  } state_e;

  typedef enum logic [2:0] {
    K_RTYPE, K_LOAD, K_STORE, K_BEQ, K_JUMP, K_ADDI, K_ANDI, K_BAD
  } kind_e;

  typedef struct packed {
    logic       mem_rd;
    logic       mem_wr;
    logic       iord;
    logic       ir_we;
    logic       mdr_we;
    logic       a_we;
    logic       b_we;
    logic       aluout_we;
    logic       reg_wr;
    logic       reg_dst;
    logic       mem_to_reg;
    logic       src_a;
    logic [1:0] src_b;
    logic [3:0] alu_ctl;
    logic       pc_we;
    logic       pc_cond;
    logic [1:0] pc_src;
    logic       epc_we;
    logic       cause_val;
  } ctl_t;

  // Control word for a state; fields not named stay zero.
  function automatic ctl_t ctl_for(state_e s, logic [3:0] r_alu, logic [3:0] i_alu);
    ctl_t c;
    c = '0;
    case (s)
      S_FETCH: begin
        c.mem_rd = 1'b1; c.ir_we = 1'b1; c.src_b = SB_STEP;
        c.alu_ctl = ALU_ADD; c.pc_we = 1'b1; c.pc_src = PS_ALU;
      end
      S_DECODE: begin
        c.a_we = 1'b1; c.b_we = 1'b1; c.aluout_we = 1'b1;
        c.src_b = SB_BOFF; c.alu_ctl = ALU_ADD;
      end
      S_MADDR: begin
        c.src_a = 1'b1; c.src_b = SB_IMM; c.alu_ctl = ALU_ADD; c.aluout_we = 1'b1;
      end
      S_MREAD: begin
        c.mem_rd = 1'b1; c.iord = 1'b1; c.mdr_we = 1'b1;
      end
      S_MWB: begin
        c.reg_wr = 1'b1; c.mem_to_reg = 1'b1;
      end
      S_MWRITE: begin
        c.mem_wr = 1'b1; c.iord = 1'b1;
      end
      S_REXEC: begin
        c.src_a = 1'b1; c.src_b = SB_REG; c.alu_ctl = r_alu; c.aluout_we = 1'b1;
      end
      S_RWB: begin
        c.reg_wr = 1'b1; c.reg_dst = 1'b1;
      end
      S_BRANCH: begin
        c.src_a = 1'b1; c.src_b = SB_REG; c.alu_ctl = ALU_SUB;
        c.pc_cond = 1'b1; c.pc_src = PS_TGT;
      end
      S_JUMP: begin
        c.pc_we = 1'b1; c.pc_src = PS_JMP;
      end
      S_IEXEC: begin
        c.src_a = 1'b1; c.src_b = SB_IMM; c.alu_ctl = i_alu; c.aluout_we = 1'b1;
      end
      S_IWB: begin
        c.reg_wr = 1'b1;
      end
      S_XUND: begin
        c.pc_we = 1'b1; c.pc_src = PS_VEC; c.epc_we = 1'b1; c.cause_val = 1'b0;
      end
      S_XOVF: begin
        c.pc_we = 1'b1; c.pc_src = PS_VEC; c.epc_we = 1'b1; c.cause_val = 1'b1;
      end
      default: ;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/mcc_decode.sv
module mcc_decode
  import mcc_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  input  logic [FN_W-1:0] funct,
  output kind_e           kind,
  output logic [3:0]      r_alu,
  output logic [3:0]      i_alu,
  output logic            ovf_trap
);

  logic fn_known;

  always_comb begin
    fn_known = 1'b1;
    r_alu    = ALU_ADD;
    case (funct)
      FN_ADD, FN_ADDU: r_alu = ALU_ADD;
      FN_SUB, FN_SUBU: r_alu = ALU_SUB;
      FN_AND:          r_alu = ALU_AND;
      FN_OR:           r_alu = ALU_OR;
      FN_SLT:          r_alu = ALU_SLT;
      default:         fn_known = 1'b0;
    endcase
  end

  assign ovf_trap = (funct == FN_ADD) || (funct == FN_SUB);
  assign i_alu    = (opcode == OP_ANDI) ? ALU_AND : ALU_ADD;

  always_comb begin
    case (opcode)
      OP_RTYPE: kind = fn_known ? K_RTYPE : K_BAD;
      OP_LOAD:  kind = K_LOAD;
      OP_STORE: kind = K_STORE;
      OP_BEQ:   kind = K_BEQ;
      OP_JUMP:  kind = K_JUMP;
      OP_ADDI:  kind = K_ADDI;
      OP_ANDI:  kind = K_ANDI;
      default:  kind = K_BAD;
    endcase
  end

endmodule

// File: rtl/mcc_seq.sv
module mcc_seq
  import mcc_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  kind_e      kind,
  input  logic [3:0] r_alu,
  input  logic [3:0] i_alu,
  input  logic       ovf_trap,
  input  logic       alu_ovf,
  output ctl_t       ctl_q
);

  state_e state_q, state_d;
  ctl_t   ctl_d;

  always_comb begin
    state_d = S_FETCH;
    case (state_q)
      S_FETCH:  state_d = S_DECODE;
      S_DECODE: begin
        case (kind)
          K_RTYPE:         state_d = S_REXEC;
          K_LOAD, K_STORE: state_d = S_MADDR;
          K_BEQ:           state_d = S_BRANCH;
          K_JUMP:          state_d = S_JUMP;
          K_ADDI, K_ANDI:  state_d = S_IEXEC;
          default:         state_d = S_XUND;
        endcase
      end
      S_MADDR:  state_d = (kind == K_LOAD) ? S_MREAD : S_MWRITE;
      S_MREAD:  state_d = S_MWB;
      S_REXEC:  state_d = (ovf_trap && alu_ovf) ? S_XOVF : S_RWB;
      S_IEXEC:  state_d = S_IWB;
      default:  state_d = S_FETCH;
    endcase
  end

  // Outputs come from a register loaded with the next state's decode.
  assign ctl_d = ctl_for(state_d, r_alu, i_alu);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_FETCH;
      ctl_q   <= ctl_for(S_FETCH, ALU_ADD, ALU_ADD);
    end else begin
      state_q <= state_d;
      ctl_q   <= ctl_d;
    end
  end

endmodule

// File: rtl/mcc_exc.sv
module mcc_exc #(
  parameter int ADDR_W  = 32,
  parameter int CAUSE_W = 32,
  parameter int PC_STEP = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               epc_we,
  input  logic               cause_val,
  input  logic [ADDR_W-1:0]  pc_in,
  output logic [ADDR_W-1:0]  epc_q,
  output logic [CAUSE_W-1:0] cause_q
);

  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(PC_STEP);

  always_ff @(posedge clk) begin
    if (rst) begin
      epc_q   <= '0;
      cause_q <= '0;
    end else if (epc_we) begin
      epc_q   <= pc_in - STEP;
      cause_q <= CAUSE_W'(cause_val);
    end
  end

endmodule

// File: rtl/mc_ctrl.sv
module mc_ctrl
  import mcc_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int CAUSE_W = 32,
  parameter int PC_STEP = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [5:0]         ir_opcode,
  input  logic [5:0]         ir_funct,
  input  logic               alu_ovf,
  input  logic [ADDR_W-1:0]  pc_in,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic               iord,
  output logic               ir_we,
  output logic               mdr_we,
  output logic               a_we,
  output logic               b_we,
  output logic               aluout_we,
  output logic               reg_wr,
  output logic               reg_dst,
  output logic               mem_to_reg,
  output logic               alu_src_a,
  output logic [1:0]         alu_src_b,
  output logic [3:0]         alu_ctl,
  output logic               pc_we,
  output logic               pc_cond,
  output logic [1:0]         pc_src,
  output logic [ADDR_W-1:0]  epc,
  output logic [CAUSE_W-1:0] cause
);

  kind_e      kind;
  logic [3:0] r_alu, i_alu;
  logic       ovf_trap;
  ctl_t       ctl_q;

  mcc_decode dec_i (
    .opcode   (ir_opcode),
    .funct    (ir_funct),
    .kind     (kind),
    .r_alu    (r_alu),
    .i_alu    (i_alu),
    .ovf_trap (ovf_trap)
  );

  mcc_seq seq_i (
    .clk      (clk),
    .rst      (rst),
    .kind     (kind),
    .r_alu    (r_alu),
    .i_alu    (i_alu),
    .ovf_trap (ovf_trap),
    .alu_ovf  (alu_ovf),
    .ctl_q    (ctl_q)
  );

  mcc_exc #(.ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W), .PC_STEP(PC_STEP)) exc_i (
    .clk       (clk),
    .rst       (rst),
    .epc_we    (ctl_q.epc_we),
    .cause_val (ctl_q.cause_val),
    .pc_in     (pc_in),
    .epc_q     (epc),
    .cause_q   (cause)
  );

  assign mem_rd     = ctl_q.mem_rd;
  assign mem_wr     = ctl_q.mem_wr;
  assign iord       = ctl_q.iord;
  assign ir_we      = ctl_q.ir_we;
  assign mdr_we     = ctl_q.mdr_we;
  assign a_we       = ctl_q.a_we;
  assign b_we       = ctl_q.b_we;
  assign aluout_we  = ctl_q.aluout_we;
  assign reg_wr     = ctl_q.reg_wr;
  assign reg_dst    = ctl_q.reg_dst;
  assign mem_to_reg = ctl_q.mem_to_reg;
  assign alu_src_a  = ctl_q.src_a;
  assign alu_src_b  = ctl_q.src_b;
  assign alu_ctl    = ctl_q.alu_ctl;
  assign pc_we      = ctl_q.pc_we;
  assign pc_cond    = ctl_q.pc_cond;
  assign pc_src     = ctl_q.pc_src;

endmodule

// File: rtl/mcc_chk.sv
module mcc_chk #(
  parameter int ADDR_W  = 32,
  parameter int CAUSE_W = 32,
  parameter int PC_STEP = 4
) (
  input logic               clk,
  input logic               rst,
  input logic               mem_rd,
  input logic               mem_wr,
  input logic               iord,
  input logic               ir_we,
  input logic               mdr_we,
  input logic               reg_wr,
  input logic               pc_we,
  input logic [1:0]         pc_src,
  input logic [ADDR_W-1:0]  pc_in,
  input logic [ADDR_W-1:0]  epc,
  input logic [CAUSE_W-1:0] cause
);

  logic trap_cyc;
  assign trap_cyc = pc_we && (pc_src == 2'd3);

  p_fetch_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (mem_rd && ir_we && !iord && pc_we && pc_src == 2'd0));

  p_mem_excl_r2: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_wr));

  p_ir_from_pc_r2: assert property (@(posedge clk) disable iff (rst)
    ir_we |-> (mem_rd && !iord));

  p_data_addr_r2: assert property (@(posedge clk) disable iff (rst)
    (mem_wr || mdr_we) |-> iord);

  p_trap_no_commit_r9: assert property (@(posedge clk) disable iff (rst)
    trap_cyc |-> !(reg_wr || mem_wr));

  p_trap_epc_r9: assert property (@(posedge clk) disable iff (rst)
    trap_cyc |=> (epc == $past(pc_in) - ADDR_W'(PC_STEP)));

  p_trap_refetch_r9: assert property (@(posedge clk) disable iff (rst)
    trap_cyc |=> (ir_we && mem_rd));

  p_cause_code_r10: assert property (@(posedge clk) disable iff (rst)
    trap_cyc |=> (cause <= CAUSE_W'(1)));

  p_record_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !trap_cyc |=> ($stable(epc) && $stable(cause)));

endmodule

bind mc_ctrl mcc_chk #(.ADDR_W(ADDR_W), .CAUSE_W(CAUSE_W), .PC_STEP(PC_STEP)) chk_i (
  .clk    (clk),
  .rst    (rst),
  .mem_rd (mem_rd),
  .mem_wr (mem_wr),
  .iord   (iord),
  .ir_we  (ir_we),
  .mdr_we (mdr_we),
  .reg_wr (reg_wr),
  .pc_we  (pc_we),
  .pc_src (pc_src),
  .pc_in  (pc_in),
  .epc    (epc),
  .cause  (cause)
);

// File: tb/mc_ctrl_tb_top.sv
`timescale 1ns/1ps
module mc_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [5:0]  ir_opcode = '0;
  logic [5:0]  ir_funct = '0;
  logic        alu_ovf = 1'b0;
  logic [31:0] pc_in = '0;
  logic mem_rd, mem_wr, iord, ir_we, mdr_we, a_we, b_we, aluout_we;
  logic reg_wr, reg_dst, mem_to_reg, alu_src_a, pc_we, pc_cond;
  logic [1:0]  alu_src_b, pc_src;
  logic [3:0]  alu_ctl;
  logic [31:0] epc, cause;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] exp_epc = '0;
  logic [31:0] exp_cause = '0;

  always #2 clk = ~clk;

  mc_ctrl dut_i (
    .clk(clk), .rst(rst), .ir_opcode(ir_opcode), .ir_funct(ir_funct),
    .alu_ovf(alu_ovf), .pc_in(pc_in), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .iord(iord), .ir_we(ir_we), .mdr_we(mdr_we), .a_we(a_we), .b_we(b_we),
    .aluout_we(aluout_we), .reg_wr(reg_wr), .reg_dst(reg_dst),
    .mem_to_reg(mem_to_reg), .alu_src_a(alu_src_a), .alu_src_b(alu_src_b),
    .alu_ctl(alu_ctl), .pc_we(pc_we), .pc_cond(pc_cond), .pc_src(pc_src),
    .epc(epc), .cause(cause)
  );

  logic [21:0] dut_w;
  assign dut_w = {mem_rd, mem_wr, iord, ir_we, mdr_we, a_we, b_we, aluout_we,
                  reg_wr, reg_dst, mem_to_reg, alu_src_a, alu_src_b, alu_ctl,
                  pc_we, pc_cond, pc_src};

  localparam logic [3:0] A_AND = 4'b0000, A_OR = 4'b0001, A_ADD = 4'b0010,
                         A_SUB = 4'b0110, A_SLT = 4'b0111;

  function automatic logic [21:0] mk(
    input logic mr, input logic mw, input logic io, input logic ir,
    input logic md, input logic ab, input logic ao, input logic rw,
    input logic rd, input logic m2r, input logic sa, input logic [1:0] sb,
    input logic [3:0] al, input logic pw, input logic pcnd, input logic [1:0] ps);
    return {mr, mw, io, ir, md, ab, ab, ao, rw, rd, m2r, sa, sb, al, pw, pcnd, ps};
  endfunction

  function automatic logic [21:0] w_fetch();  return mk(1,0,0,1,0,0,0,0,0,0,0,2'd1,A_ADD,1,0,2'd0); endfunction
  function automatic logic [21:0] w_dec();    return mk(0,0,0,0,0,1,1,0,0,0,0,2'd3,A_ADD,0,0,2'd0); endfunction
  function automatic logic [21:0] w_maddr();  return mk(0,0,0,0,0,0,1,0,0,0,1,2'd2,A_ADD,0,0,2'd0); endfunction
  function automatic logic [21:0] w_mread();  return mk(1,0,1,0,1,0,0,0,0,0,0,2'd0,A_AND,0,0,2'd0); endfunction
  function automatic logic [21:0] w_mwb();    return mk(0,0,0,0,0,0,0,1,0,1,0,2'd0,A_AND,0,0,2'd0); endfunction
  function automatic logic [21:0] w_mwrite(); return mk(0,1,1,0,0,0,0,0,0,0,0,2'd0,A_AND,0,0,2'd0); endfunction
  function automatic logic [21:0] w_rex(input logic [3:0] al); return mk(0,0,0,0,0,0,1,0,0,0,1,2'd0,al,0,0,2'd0); endfunction
  function automatic logic [21:0] w_rwb();    return mk(0,0,0,0,0,0,0,1,1,0,0,2'd0,A_AND,0,0,2'd0); endfunction
  function automatic logic [21:0] w_br();     return mk(0,0,0,0,0,0,0,0,0,0,1,2'd0,A_SUB,0,1,2'd1); endfunction
  function automatic logic [21:0] w_jmp();    return mk(0,0,0,0,0,0,0,0,0,0,0,2'd0,A_AND,1,0,2'd2); endfunction
  function automatic logic [21:0] w_iex(input logic [3:0] al); return mk(0,0,0,0,0,0,1,0,0,0,1,2'd2,al,0,0,2'd0); endfunction
  function automatic logic [21:0] w_iwb();    return mk(0,0,0,0,0,0,0,1,0,0,0,2'd0,A_AND,0,0,2'd0); endfunction
  function automatic logic [21:0] w_trap();   return mk(0,0,0,0,0,0,0,0,0,0,0,2'd0,A_AND,1,0,2'd3); endfunction

  // Instruction kinds: 0 R, 1 load, 2 store, 3 beq, 4 jump, 5 addi, 6 andi, 7 undefined
  function automatic logic fn_ok(input logic [5:0] fn);
    return fn inside {6'h20, 6'h21, 6'h22, 6'h23, 6'h24, 6'h25, 6'h2A};
  endfunction

  function automatic int kind_of(input logic [5:0] op, input logic [5:0] fn);
    case (op)
      6'h00: return fn_ok(fn) ? 0 : 7;
      6'h23: return 1;
      6'h2B: return 2;
      6'h04: return 3;
      6'h02: return 4;
      6'h08: return 5;
      6'h0C: return 6;
      default: return 7;
    endcase
  endfunction

  function automatic logic [3:0] ralu(input logic [5:0] fn);
    case (fn)
      6'h22, 6'h23: return A_SUB;
      6'h24: return A_AND;
      6'h25: return A_OR;
      6'h2A: return A_SLT;
      default: return A_ADD;
    endcase
  endfunction

  task automatic chk(input logic [31:0] got, input logic [31:0] exp, input string req);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h at %0t", req, got, exp, $time);
    end
  endtask

  // Entered in the fetch cycle just after a falling edge; returns in the next fetch cycle.
  task automatic run_instr(input logic [5:0] op, input logic [5:0] fn,
                           input logic ovf, input logic [31:0] pc);
    logic [21:0] ew [6];
    string       et [6];
    int          n;
    int          k;
    logic        trap;
    logic        cval;
    string       ttag;
    ir_opcode = op; ir_funct = fn; alu_ovf = ovf; pc_in = pc;
    ew[0] = w_fetch(); et[0] = "R2";
    ew[1] = w_dec();   et[1] = "R3";
    n = 2; trap = 1'b0; cval = 1'b0; ttag = "R9";
    k = kind_of(op, fn);
    case (k)
      0: begin
        ew[2] = w_rex(ralu(fn)); et[2] = "R4";
        if (ovf && (fn == 6'h20 || fn == 6'h22)) begin
          ew[3] = w_trap(); et[3] = "R10"; trap = 1'b1; cval = 1'b1; ttag = "R10";
        end else begin
          ew[3] = w_rwb(); et[3] = ovf ? "R10" : "R4";
        end
        n = 4;
      end
      1: begin ew[2] = w_maddr(); et[2] = "R5"; ew[3] = w_mread(); et[3] = "R5";
               ew[4] = w_mwb(); et[4] = "R5"; n = 5; end
      2: begin ew[2] = w_maddr(); et[2] = "R6"; ew[3] = w_mwrite(); et[3] = "R6"; n = 4; end
      3: begin ew[2] = w_br(); et[2] = "R7"; n = 3; end
      4: begin ew[2] = w_jmp(); et[2] = "R7"; n = 3; end
      5: begin ew[2] = w_iex(A_ADD); et[2] = "R8"; ew[3] = w_iwb(); et[3] = "R8"; n = 4; end
      6: begin ew[2] = w_iex(A_AND); et[2] = "R8"; ew[3] = w_iwb(); et[3] = "R8"; n = 4; end
      default: begin ew[2] = w_trap(); et[2] = "R9"; trap = 1'b1; n = 3; end
    endcase
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      chk({10'd0, dut_w}, {10'd0, ew[i]}, et[i]);
    end
    @(negedge clk);
    if (trap) begin
      exp_epc   = pc - 32'd4;
      exp_cause = {31'd0, cval};
    end
    chk(epc,   exp_epc,   trap ? ttag : "R11");
    chk(cause, exp_cause, trap ? ttag : "R11");
  endtask

  function automatic logic [5:0] pick_op(input int idx);
    case (idx)
      0: return 6'h00; 1: return 6'h23; 2: return 6'h2B; 3: return 6'h04;
      4: return 6'h02; 5: return 6'h08; default: return 6'h0C;
    endcase
  endfunction

  function automatic logic [5:0] pick_fn(input int idx);
    case (idx)
      0: return 6'h20; 1: return 6'h21; 2: return 6'h22; 3: return 6'h23;
      4: return 6'h24; 5: return 6'h25; default: return 6'h2A;
    endcase
  endfunction

  logic done = 1'b0;

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: first cycle after reset is fetch; record registers cleared
    chk({10'd0, dut_w}, {10'd0, w_fetch()}, "R1");
    chk(epc, 32'd0, "R1");
    chk(cause, 32'd0, "R1");

    // Directed cases
    run_instr(6'h00, 6'h20, 1'b0, 32'h0000_1004);   // add, no overflow (R4)
    run_instr(6'h00, 6'h20, 1'b1, 32'h0000_2008);   // add traps (R10)
    run_instr(6'h00, 6'h21, 1'b1, 32'h0000_300C);   // addu ignores overflow (R10)
    run_instr(6'h00, 6'h22, 1'b1, 32'h0000_4010);   // sub traps (R10)
    run_instr(6'h00, 6'h23, 1'b1, 32'h0000_4014);   // subu ignores overflow
    run_instr(6'h00, 6'h24, 1'b1, 32'h0000_4018);   // and ignores overflow
    run_instr(6'h00, 6'h25, 1'b0, 32'h0000_401C);
    run_instr(6'h00, 6'h2A, 1'b0, 32'h0000_4020);
    run_instr(6'h23, 6'h00, 1'b1, 32'h0000_5004);   // load (R5)
    run_instr(6'h2B, 6'h00, 1'b0, 32'h0000_5008);   // store (R6)
    run_instr(6'h04, 6'h00, 1'b0, 32'h0000_500C);   // beq (R7)
    run_instr(6'h02, 6'h00, 1'b0, 32'h0000_5010);   // jump (R7)
    run_instr(6'h08, 6'h00, 1'b1, 32'h0000_5014);   // addi ignores overflow (R8)
    run_instr(6'h0C, 6'h00, 1'b0, 32'h0000_5018);   // andi (R8)
    run_instr(6'h3F, 6'h00, 1'b0, 32'h0000_6004);   // undefined opcode (R9)
    run_instr(6'h00, 6'h00, 1'b0, 32'h0000_0004);   // R-type, unknown funct (R9)
    run_instr(6'h00, 6'h3F, 1'b1, 32'h0000_0000);   // unknown funct, PC wraps below zero
    run_instr(6'h2B, 6'h00, 1'b0, 32'hFFFF_FFFC);   // record held (R11)

    // Random instruction stream
    for (int t = 0; t < 600; t++) begin
      logic [5:0] op, fn;
      op = ($urandom % 10 < 7) ? pick_op($urandom % 7) : 6'($urandom);
      fn = ($urandom % 4 == 0) ? 6'($urandom) : pick_fn($urandom % 7);
      run_instr(op, fn, 1'($urandom), $urandom);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

endmodule